// File: doc/BRIEF.md
# Masked Pattern Search Comparator

This block serves one DMA channel during search and transfer-and-search operations. Each time a datum is read, the block compares it with a programmed pattern. Bits whose mask bit is set are left out of the comparison. It reports a hit on the upper byte and a hit on the lower byte separately. From those hits and the operation size (byte or word) it forms one match decision. A programmable polarity turns that decision into a terminate request, so the channel stops either at the first datum that matches or at the first datum that does not.

The terminate request is combinational. It appears in the same cycle as the qualified data strobe, so the transfer engine can stop on that datum. Three sticky status flags record what happened since the last start command: an upper-byte hit, a lower-byte hit, and a search-caused termination. A start pulse or a reset clears them.

Top module: `pat_search`

## Requirements
- R1: A mask bit of 1 removes the corresponding data bit from the comparison. A lane hits when every unmasked data bit equals the pattern bit, so an all-ones mask gives a hit for any data.
- R2: In word mode (`byte_mode_i`=0), a qualified strobe whose bits 15:8 hit sets `match_hi_o`. In byte mode (`byte_mode_i`=1), the upper byte is not compared and `match_hi_o` is never set.
- R3: A qualified strobe whose bits 7:0 hit sets `match_lo_o`, in both byte and word mode.
- R4: The match decision is the AND of both byte hits in word mode, and the lower-byte hit alone in byte mode.
- R5: With `stop_on_match_i`=1, `term_o` is asserted when the decision is true. With `stop_on_match_i`=0, `term_o` is asserted when the decision is false.
- R6: `term_o` is asserted only in a cycle where `strobe_i` and `search_en_i` are both high. A strobe with `search_en_i` low sets no flag and gives no terminate request.
- R7: `match_cnt_o` goes high on the clock edge that ends a cycle in which `term_o` was high.
- R8: All three flags are sticky. They clear only on `start_i` or reset, and `start_i` takes priority over a strobe in the same cycle.
- R9: Asynchronous reset (`rst_ni` low) clears all three flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command, clears the status flags |
| strobe_i | input | 1 | Datum valid this cycle |
| search_en_i | input | 1 | Channel is in a search operation |
| byte_mode_i | input | 1 | 1 = byte operation, 0 = word operation |
| stop_on_match_i | input | 1 | 1 = stop on match, 0 = stop on no match |
| data_i | input | 16 | Datum read |
| pattern_i | input | 16 | Comparison pattern |
| mask_i | input | 16 | Exclusion mask, 1 = bit ignored |
| term_o | output | 1 | Terminate request, same cycle as the strobe |
| match_hi_o | output | 1 | Sticky upper-byte hit |
| match_lo_o | output | 1 | Sticky lower-byte hit |
| match_cnt_o | output | 1 | Sticky search-caused termination |

## Verification
The main sweep uses four patterns and four masks. Each data value is the pattern with selected nibbles of both bytes flipped. This includes a mask that covers exactly the flipped nibbles, which tells true masking apart from a plain compare. It also includes a mask that covers only the low byte, which separates the two byte lanes. Every data value is run in both size modes and both stop polarities. This tells an AND-of-lanes decision apart from a low-lane-only decision, and an inverted stop apart from a direct one. Directed sequences then check that the flags stay set across a mismatching datum, that a start wins over a same-cycle strobe, and that a strobe with search disabled leaves everything untouched.

// File: rtl/psc_pkg.sv
`timescale 1ns/1ps
package psc_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned LANE_W = 8;

  typedef struct packed {
    logic hi;
    logic lo;
    logic cnt;
  } psc_flags_t;
endpackage

// File: rtl/psc_lane_cmp.sv
`timescale 1ns/1ps
module psc_lane_cmp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] pattern_i,
  input  logic [W-1:0] mask_i,
  output logic         hit_o
);
  logic [W-1:0] diff;

  // mask bit set -> bit excluded
  assign diff  = (data_i ^ pattern_i) & ~mask_i;
  assign hit_o = ~|diff;
endmodule

// File: rtl/psc_decide.sv
`timescale 1ns/1ps
module psc_decide #(
  parameter int unsigned LANES = 2
) (
  input  logic             qual_i,
  input  logic             byte_mode_i,
  input  logic             stop_on_match_i,
  input  logic [LANES-1:0] lane_hit_i,
  output logic             term_o
);
  logic decision;

  always_comb begin
    if (byte_mode_i) decision = lane_hit_i[0];
    else             decision = &lane_hit_i;
  end

  assign term_o = qual_i & (stop_on_match_i ? decision : ~decision);
endmodule

// File: rtl/psc_flags.sv
`timescale 1ns/1ps
module psc_flags
  import psc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       qual_i,
  input  logic       byte_mode_i,
  input  logic       hit_hi_i,
  input  logic       hit_lo_i,
  input  logic       term_i,
  output psc_flags_t flags_o
);
  psc_flags_t q, d;

  always_comb begin
    d = q;
    if (start_i) begin
      d = '0;
    end else begin
      if (qual_i && !byte_mode_i && hit_hi_i) d.hi  = 1'b1;
      if (qual_i && hit_lo_i)                 d.lo  = 1'b1;
      if (term_i)                             d.cnt = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign flags_o = q;
endmodule

// File: rtl/pat_search.sv
`timescale 1ns/1ps
module pat_search
  import psc_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  parameter int unsigned BYTE_W = LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              strobe_i,
  input  logic              search_en_i,
  input  logic              byte_mode_i,
  input  logic              stop_on_match_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] pattern_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              term_o,
  output logic              match_hi_o,
  output logic              match_lo_o,
  output logic              match_cnt_o
);
  localparam int unsigned LANES = DATA_W / BYTE_W;

  logic [LANES-1:0] lane_hit;
  logic             qual;
  logic             term;
  psc_flags_t       flags;

  // a start cycle discards any strobe
  assign qual = strobe_i & search_en_i & ~start_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    psc_lane_cmp #(.W(BYTE_W)) u_cmp (
      .data_i    (data_i   [g*BYTE_W +: BYTE_W]),
      .pattern_i (pattern_i[g*BYTE_W +: BYTE_W]),
      .mask_i    (mask_i   [g*BYTE_W +: BYTE_W]),
      .hit_o     (lane_hit[g])
    );
  end

  psc_decide #(.LANES(LANES)) u_decide (
    .qual_i          (qual),
    .byte_mode_i     (byte_mode_i),
    .stop_on_match_i (stop_on_match_i),
    .lane_hit_i      (lane_hit),
    .term_o          (term)
  );

  psc_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .qual_i      (qual),
    .byte_mode_i (byte_mode_i),
    .hit_hi_i    (lane_hit[LANES-1]),
    .hit_lo_i    (lane_hit[0]),
    .term_i      (term),
    .flags_o     (flags)
  );

  assign term_o      = term;
  assign match_hi_o  = flags.hi;
  assign match_lo_o  = flags.lo;
  assign match_cnt_o = flags.cnt;
endmodule

// File: rtl/pat_search_chk.sv
`timescale 1ns/1ps
module pat_search_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              strobe_i,
  input logic              search_en_i,
  input logic              byte_mode_i,
  input logic              stop_on_match_i,
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] pattern_i,
  input logic [DATA_W-1:0] mask_i,
  input logic              term_o,
  input logic              match_hi_o,
  input logic              match_lo_o,
  input logic              match_cnt_o
);
  assert_term_qualified_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |-> (strobe_i && search_en_i));

  assert_full_mask_stops_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '1 && strobe_i && search_en_i && !start_i && stop_on_match_i) |-> term_o);

  assert_lo_exact_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && search_en_i && !start_i && data_i[BYTE_W-1:0] == pattern_i[BYTE_W-1:0])
    |=> match_lo_o);

  assert_byte_mode_no_hi_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_mode_i && !match_hi_o) |=> !match_hi_o);

  assert_cnt_after_term_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |=> match_cnt_o);

  assert_cnt_needs_term_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!match_cnt_o && !term_o) |=> !match_cnt_o);

  assert_start_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!match_cnt_o && !match_hi_o && !match_lo_o));

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_cnt_o && match_lo_o && !start_i) |=> (match_cnt_o && match_lo_o));
endmodule

bind pat_search pat_search_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/pat_search_bench.sv
`timescale 1ns/1ps
module pat_search_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        strobe_i = 1'b0;
  logic        search_en_i = 1'b0;
  logic        byte_mode_i = 1'b0;
  logic        stop_on_match_i = 1'b0;
  logic [15:0] data_i = '0;
  logic [15:0] pattern_i = '0;
  logic [15:0] mask_i = '0;
  logic        term_o, match_hi_o, match_lo_o, match_cnt_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  pat_search u_pat_search (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h (data=%h pat=%h mask=%h byte=%0d pol=%0d)",
               req, act, exp, data_i, pattern_i, mask_i, byte_mode_i, stop_on_match_i);
    end
  endtask

  function automatic bit hit(input logic [7:0] d, input logic [7:0] p, input logic [7:0] m);
    return ((d ^ p) & ~m) == 8'h00;
  endfunction

  task automatic pulse_start();
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // one strobe at the current negedge; term checked mid-cycle, flags at next negedge
  task automatic strobe(input logic [15:0] d, output logic t);
    data_i   = d;
    strobe_i = 1'b1;
    #2;
    t = term_o;
    @(negedge clk_i);
    strobe_i = 1'b0;
  endtask

  task automatic sweep_vec(input logic [15:0] d, input logic [15:0] p, input logic [15:0] m,
                           input bit bm, input bit pol);
    bit hh, hl, dec, et;
    logic t;
    hh  = hit(d[15:8], p[15:8], m[15:8]);
    hl  = hit(d[7:0], p[7:0], m[7:0]);
    dec = bm ? hl : (hh & hl);
    et  = pol ? dec : !dec;
    pattern_i = p;
    mask_i = m;
    byte_mode_i = bm;
    stop_on_match_i = pol;
    pulse_start();
    strobe(d, t);
    chk(bm ? "R4/R5 term byte" : "R4/R5 term word", {15'd0, t}, {15'd0, et});
    chk("R2 match_hi", {15'd0, match_hi_o}, {15'd0, !bm && hh});
    chk("R3 match_lo", {15'd0, match_lo_o}, {15'd0, hl});
    chk("R7 match_cnt", {15'd0, match_cnt_o}, {15'd0, et});
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [4];
    logic [15:0] masks [4];
    logic t;
    pats[0] = 16'hA5C3; pats[1] = 16'h0000; pats[2] = 16'hFFFF; pats[3] = 16'h3C96;
    masks[0] = 16'h0000; masks[1] = 16'h0F0F; masks[2] = 16'h00FF; masks[3] = 16'hFFFF;

    // R9 reset state
    repeat (3) @(negedge clk_i);
    chk("R9 reset hi", {15'd0, match_hi_o}, 16'd0);
    chk("R9 reset lo", {15'd0, match_lo_o}, 16'd0);
    chk("R9 reset cnt", {15'd0, match_cnt_o}, 16'd0);
    rst_ni = 1'b1;
    search_en_i = 1'b1;

    // R1..R5, R7 sweep: flips confined to the low nibbles of each byte
    for (int pi = 0; pi < 4; pi++)
      for (int mi = 0; mi < 4; mi++)
        for (int dv = 0; dv < 256; dv++)
          for (int mode = 0; mode < 4; mode++) begin
            logic [7:0] f;
            f = dv[7:0];
            sweep_vec(pats[pi] ^ {4'h0, f[7:4], 4'h0, f[3:0]}, pats[pi], masks[mi],
                      mode[0], mode[1]);
          end

    // R8 sticky: low hit then a full mismatch, flags persist
    pattern_i = 16'h1234; mask_i = 16'h0000; byte_mode_i = 1'b0; stop_on_match_i = 1'b0;
    pulse_start();
    strobe(16'hFF34, t);
    chk("R5 no-match stop", {15'd0, t}, 16'd1);
    strobe(16'h00CB, t);
    chk("R8 sticky lo", {15'd0, match_lo_o}, 16'd1);
    chk("R8 sticky cnt", {15'd0, match_cnt_o}, 16'd1);
    chk("R8 hi never set", {15'd0, match_hi_o}, 16'd0);

    // R8 start wins over a same-cycle strobe
    stop_on_match_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b1;
    data_i = 16'h1234;
    strobe_i = 1'b1;
    #2;
    chk("R8 term during start", {15'd0, term_o}, 16'd0);
    @(negedge clk_i);
    start_i = 1'b0;
    strobe_i = 1'b0;
    chk("R8 start clears lo", {15'd0, match_lo_o}, 16'd0);
    chk("R8 start clears hi", {15'd0, match_hi_o}, 16'd0);
    chk("R8 start clears cnt", {15'd0, match_cnt_o}, 16'd0);

    // R6 strobe with search disabled
    search_en_i = 1'b0;
    strobe(16'h1234, t);
    chk("R6 term disabled", {15'd0, t}, 16'd0);
    chk("R6 flags disabled", {13'd0, match_hi_o, match_lo_o, match_cnt_o}, 16'd0);
    search_en_i = 1'b1;
    // R6 no strobe, matching data present
    data_i = 16'h1234;
    #2;
    chk("R6 term no strobe", {15'd0, term_o}, 16'd0);

    // R9 mid-run reset
    @(negedge clk_i);
    strobe(16'h1234, t);
    chk("R7 cnt set before reset", {15'd0, match_cnt_o}, 16'd1);
    rst_ni = 1'b0;
    #2;
    chk("R9 async clear", {13'd0, match_hi_o, match_lo_o, match_cnt_o}, 16'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule